// File: doc/BRIEF.md
# Demultiplexed External Bus Cycle Sequencer

This block runs one read or one write at a time on an external bus whose address and data lines are separate. Its clock period is one timing unit: every phase of a bus cycle is a whole number of clock periods. A requester presents an address, a direction, write data and a per-cycle configuration: an address-latch-pulse extension count, a strobe-delay enable, a wait-state count and a recovery (float) count. The block drives the address, the address latch pulse, the active-low read and write strobes, and the write data with its output enable.

A bus cycle is a chain of phases. The latch pulse is high for its base unit plus the extension. A gap follows, as long as the extension plus one unit when the strobe delay is on. The strobe is then low for its base width plus the wait states. The base width is two units with the delay and three without, so the delay moves the strobe fall later at the cost of strobe width. A recovery phase of the float count follows. Read data is sampled on the clock edge that raises the read strobe. It is returned with a one-cycle done pulse when the cycle ends.

The reset input is asserted asynchronously and released in step with the clock.

Top module: `demux_bus_seq`

## Requirements
- R1: While reset is applied and after it is released with no request: busy low, latch pulse low, both strobes high, data output enable low, done low.
- R2: A request (req_valid high at a rising edge) is taken only while busy is low; one presented while busy is ignored: it starts no latch pulse, changes neither the address nor the strobes, and produces no extra done.
- R3: On the edge that takes a request, bus_addr shows the request address and the latch pulse rises. The pulse stays high for 1 + E clock periods (E = extension count), and the address holds for the whole cycle.
- R4: Counting the accepting edge as edge 0, the active strobe falls at edge 1 + 2E + D (D = 1 when the strobe delay is enabled, else 0). It never overlaps the latch pulse.
- R5: The strobe stays low for 3 - D + W clock periods (W = wait-state count). It rises at edge 4 + 2E + W.
- R6: The done pulse is high for exactly one clock period, starting at edge 4 + 2E + W + F (F = float count).
- R7: On a write, bus_dout carries the write data and the output enable is high from edge 0 until edge T + 1 (T = 4 + 2E + W + F). The hold after the write strobe rises is therefore 1 + F periods.
- R8: On a read, rsp_rdata becomes, together with the done pulse, the bus_din value sampled at the edge that raises the read strobe.
- R9: The output enable is never high while the read strobe is low, and the two strobes are never low together; a read keeps the write strobe high and a write keeps the read strobe high.
- R10: busy is high from edge 0 up to edge T and low in the done cycle; when busy is low the latch pulse is low and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one timing unit |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| cfg_rw_delay | input | 1 | Strobe delay enable (D) |
| cfg_ale_ext | input | EXT_W | Latch pulse extension count (E) |
| cfg_wait | input | WAIT_W | Wait-state count (W) |
| cfg_float | input | FLT_W | Recovery count (F) |
| busy | output | 1 | Cycle in progress |
| bus_addr | output | ADDR_W | External address |
| bus_ale | output | 1 | Address latch pulse, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_dout_en | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from the bus |
| rsp_done | output | 1 | One-cycle end-of-cycle pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The sweep covers both directions, the strobe delay on and off, extensions 0 to 2, wait counts 0, 1 and 3, and float counts 0 and 2. It locates every edge of the latch pulse, strobes, enable, busy and done against formulas in E, D, W and F. A zero extension with no delay checks that the strobe falls on the very edge that drops the latch pulse. Nonzero waits and floats show that each count lands in its own phase. The read bus input changes every period, so a capture one edge early or late returns a different word. A separate test offers a request in mid-cycle and checks that it is dropped.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_GAP   = 3'd2,
    PH_STRB  = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;
endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dbs_phase_cnt.sv
module dbs_phase_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dbs_phase_fsm.sv
module dbs_phase_fsm
  import dbs_pkg::*;
#(
  parameter int EXT_W  = 2,
  parameter int WAIT_W = 4,
  parameter int FLT_W  = 3,
  parameter int CW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              cfg_rw_delay,
  input  logic [EXT_W-1:0]  cfg_ale_ext,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [FLT_W-1:0]  cfg_float,
  input  logic              cnt_zero,
  output logic              cnt_load,
  output logic [CW-1:0]     cnt_val,
  output logic              accept,
  output logic              strobe_end,
  output logic              finish,
  output logic              idle,
  output logic              is_write,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              done_o
);
  phase_e            ph_q, ph_d;
  logic              wr_q, dly_q;
  logic [EXT_W-1:0]  ext_q;
  logic [WAIT_W-1:0] wait_q;
  logic [FLT_W-1:0]  flt_q;
  logic              ale_q, rd_n_q, wr_n_q, done_q;
  logic [CW-1:0]     gap_len, strb_m1;

  assign idle   = (ph_q == PH_IDLE);
  assign accept = idle && req_valid;

  always_comb begin
    gap_len = CW'(ext_q) + CW'(dly_q);
    strb_m1 = (dly_q ? CW'(1) : CW'(2)) + CW'(wait_q);
  end

  // next phase and counter load
  always_comb begin
    ph_d     = ph_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_d     = PH_ADDR;
        cnt_load = 1'b1;
        cnt_val  = CW'(cfg_ale_ext);
      end
      PH_ADDR: if (cnt_zero) begin
        cnt_load = 1'b1;
        if (gap_len == '0) begin
          ph_d    = PH_STRB;
          cnt_val = strb_m1;
        end else begin
          ph_d    = PH_GAP;
          cnt_val = gap_len - CW'(1);
        end
      end
      PH_GAP: if (cnt_zero) begin
        ph_d     = PH_STRB;
        cnt_load = 1'b1;
        cnt_val  = strb_m1;
      end
      PH_STRB: if (cnt_zero) begin
        if (flt_q == '0) begin
          ph_d = PH_IDLE;
        end else begin
          ph_d     = PH_RECOV;
          cnt_load = 1'b1;
          cnt_val  = CW'(flt_q) - CW'(1);
        end
      end
      PH_RECOV: if (cnt_zero) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign strobe_end = (ph_q == PH_STRB) && cnt_zero;
  assign finish     = !idle && (ph_d == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // per-cycle configuration, latched when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      dly_q  <= 1'b0;
      ext_q  <= '0;
      wait_q <= '0;
      flt_q  <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      dly_q  <= cfg_rw_delay;
      ext_q  <= cfg_ale_ext;
      wait_q <= cfg_wait;
      flt_q  <= cfg_float;
    end
  end

  // registered bus controls decoded from the next phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      ale_q  <= (ph_d == PH_ADDR);
      rd_n_q <= !((ph_d == PH_STRB) && !wr_q);
      wr_n_q <= !((ph_d == PH_STRB) && wr_q);
      done_q <= finish;
    end
  end

  assign is_write = wr_q;
  assign ale_o    = ale_q;
  assign rd_n_o   = rd_n_q;
  assign wr_n_o   = wr_n_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dbs_datapath.sv
module dbs_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              idle,
  input  logic              is_write,
  input  logic              strobe_end,
  input  logic              finish,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, cap_q, rdata_q, rdata_d;
  logic              oe_q, oe_d, oe_en, cap_en, rdata_en;

  always_comb begin
    oe_en    = accept || idle;
    oe_d     = accept && req_write;
    cap_en   = strobe_end && !is_write;
    rdata_en = finish && !is_write;
    rdata_d  = cap_en ? bus_din : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oe_q <= 1'b0;
    else if (oe_en) oe_q <= oe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign addr_o    = addr_q;
  assign dout_o    = wdata_q;
  assign dout_en_o = oe_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/demux_bus_seq.sv
module demux_bus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int EXT_W  = 2,
  parameter int WAIT_W = 4,
  parameter int FLT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_rw_delay,
  input  logic [EXT_W-1:0]  cfg_ale_ext,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [FLT_W-1:0]  cfg_float,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int MAX_A = (EXT_W > WAIT_W) ? EXT_W : WAIT_W;
  localparam int MAX_B = (MAX_A > FLT_W) ? MAX_A : FLT_W;
  localparam int CW    = MAX_B + 2;

  logic          srst_n;
  logic          cnt_load, cnt_zero;
  logic [CW-1:0] cnt_val;
  logic          accept, strobe_end, finish, idle, is_write;

  dbs_rst_sync i_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dbs_phase_cnt #(.CW(CW)) i_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  dbs_phase_fsm #(
    .EXT_W (EXT_W),
    .WAIT_W(WAIT_W),
    .FLT_W (FLT_W),
    .CW    (CW)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .cfg_rw_delay (cfg_rw_delay),
    .cfg_ale_ext  (cfg_ale_ext),
    .cfg_wait     (cfg_wait),
    .cfg_float    (cfg_float),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val),
    .accept       (accept),
    .strobe_end   (strobe_end),
    .finish       (finish),
    .idle         (idle),
    .is_write     (is_write),
    .ale_o        (bus_ale),
    .rd_n_o       (bus_rd_n),
    .wr_n_o       (bus_wr_n),
    .done_o       (rsp_done)
  );

  dbs_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (srst_n),
    .accept     (accept),
    .idle       (idle),
    .is_write   (is_write),
    .strobe_end (strobe_end),
    .finish     (finish),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .bus_din    (bus_din),
    .addr_o     (bus_addr),
    .dout_o     (bus_dout),
    .dout_en_o  (bus_dout_en),
    .rdata_o    (rsp_rdata)
  );

  assign busy = !idle;
endmodule

// File: rtl/demux_bus_seq_chk.sv
module demux_bus_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ale,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_dout_en,
  input logic              rsp_done
);
  assert_no_oe_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_dout_en);

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_ale_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_ale && bus_rd_n && bus_wr_n));

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!busy && $past(busy)));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

  assert_write_data_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_dout_en);
endmodule

bind demux_bus_seq demux_bus_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .bus_addr    (bus_addr),
  .bus_ale     (bus_ale),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_dout_en (bus_dout_en),
  .rsp_done    (rsp_done)
);

// File: tb/test_demux_bus_seq.sv
module test_demux_bus_seq;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write, cfg_rw_delay;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, bus_din;
  logic [1:0]    cfg_ale_ext;
  logic [3:0]    cfg_wait;
  logic [2:0]    cfg_float;
  logic          busy, bus_ale, bus_rd_n, bus_wr_n, bus_dout_en, rsp_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, rsp_rdata;

  int n_checks = 0;
  int n_errors = 0;

  demux_bus_seq i_demux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_rw_delay(cfg_rw_delay),
    .cfg_ale_ext(cfg_ale_ext), .cfg_wait(cfg_wait), .cfg_float(cfg_float),
    .busy(busy), .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // one full bus cycle, observed at every falling edge; k = rising edges since acceptance
  task automatic run_cycle(input bit wr, input bit d, input int a, input int w,
                           input int f, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    int t, sfall, srise, fall_at, rise_at, bad_ale, bad_addr, bad_other, bad_busy;
    int bad_done, bad_oe, bad_r9;
    logic [DW-1:0] pat, exp_rd, got_rd;
    bit act_low;
    string cfg;
    t = 4 + 2*a + w + f;
    sfall = 1 + 2*a + d;
    srise = 4 + 2*a + w;
    pat = wd ^ 16'h5A3C;
    exp_rd = pat ^ DW'(srise - 1);
    got_rd = '0;
    fall_at = -1; rise_at = -1;
    bad_ale = 0; bad_addr = 0; bad_other = 0; bad_busy = 0;
    bad_done = 0; bad_oe = 0; bad_r9 = 0;
    cfg = $sformatf("wr=%0d d=%0d E=%0d W=%0d F=%0d", wr, d, a, w, f);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    cfg_rw_delay = d; cfg_ale_ext = 2'(a); cfg_wait = 4'(w); cfg_float = 3'(f);
    for (int k = 0; k <= t + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      act_low = wr ? !bus_wr_n : !bus_rd_n;
      if (act_low && fall_at < 0) fall_at = k;
      if (!act_low && fall_at >= 0 && rise_at < 0) rise_at = k;
      if (bus_ale !== (k <= a)) bad_ale++;
      if (k <= t && bus_addr !== ad) bad_addr++;
      if ((wr ? !bus_rd_n : !bus_wr_n)) bad_other++;
      if (busy !== (k < t)) bad_busy++;
      if (rsp_done !== (k == t)) bad_done++;
      if (bus_dout_en !== (wr && k <= t)) bad_oe++;
      if (wr && k <= t && bus_dout !== wd) bad_oe++;
      if (!bus_rd_n && bus_dout_en) bad_r9++;
      if (k == t) got_rd = rsp_rdata;
      bus_din = pat ^ DW'(k);
    end
    check(bad_ale == 0, "R3", {"ALE pulse ", cfg}, bad_ale, 0);
    check(bad_addr == 0, "R3", {"address hold ", cfg}, bad_addr, 0);
    check(fall_at == sfall, "R4", {"strobe fall edge ", cfg}, fall_at, sfall);
    check(rise_at == srise, "R5", {"strobe rise edge ", cfg}, rise_at, srise);
    check(bad_done == 0, "R6", {"done position ", cfg}, bad_done, 0);
    check(bad_oe == 0, "R7", {"write data enable ", cfg}, bad_oe, 0);
    check(bad_other == 0 && bad_r9 == 0, "R9", {"strobe exclusion ", cfg},
          bad_other + bad_r9, 0);
    check(bad_busy == 0, "R10", {"busy window ", cfg}, bad_busy, 0);
    if (!wr) check(got_rd == exp_rd, "R8", {"read capture ", cfg}, int'(got_rd), int'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int wl[3];
    int ales, dones, wlow;
    wl = '{0, 1, 3};
    rst_n = 1'b0; req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234;
    req_wdata = 16'hBEEF; cfg_rw_delay = 1'b0; cfg_ale_ext = '0; cfg_wait = '0;
    cfg_float = '0; bus_din = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while a request is held at the inputs
    check(!busy && !bus_ale && bus_rd_n && bus_wr_n && !bus_dout_en && !rsp_done,
          "R1", "outputs in reset", {busy, bus_ale, bus_rd_n, bus_wr_n, bus_dout_en, rsp_done}, 6'b001100);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !bus_ale && bus_rd_n && bus_wr_n && !bus_dout_en && !rsp_done,
          "R1", "outputs after reset release", {busy, bus_ale, bus_rd_n, bus_wr_n, bus_dout_en, rsp_done}, 6'b001100);

    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 3; a++)
        for (int wi = 0; wi < 3; wi++)
          for (int f = 0; f <= 2; f += 2)
            for (int wr = 0; wr < 2; wr++)
              run_cycle(wr[0], d[0], a, wl[wi], f, AW'(16'h0100 + a*16 + wi*4 + f),
                        DW'(16'hA000 ^ (d*97 + a*31 + wi*7 + f*3 + wr)));

    // R2: a request offered mid-cycle is dropped
    ales = 0; dones = 0; wlow = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0A11;
    cfg_rw_delay = 1'b0; cfg_ale_ext = '0; cfg_wait = '0; cfg_float = '0;
    for (int k = 0; k <= 7; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
      end
      if (k == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0B22;
      end
      if (k == 3) req_valid = 1'b0;
      if (bus_ale) ales++;
      if (rsp_done) dones++;
      if (!bus_wr_n) wlow++;
    end
    check(ales == 1, "R2", "latch pulses for one taken request", ales, 1);
    check(dones == 1, "R2", "done pulses for one taken request", dones, 1);
    check(wlow == 0, "R2", "write strobe from dropped request", wlow, 0);
    check(bus_addr == 16'h0A11, "R2", "address after dropped request", int'(bus_addr), 16'h0A11);
    summary();
  end
endmodule